// File: doc/BRIEF.md
# Instruction Prefetch Line Buffer

This block sits between a processor's instruction-fetch port and a slow flash array whose line reads take a run-time number of wait states. Each flash read delivers a 64-bit line containing four 16-bit instruction halfwords. The buffer keeps two line slots: the line the processor is executing from, and a speculatively read following line. A halfword request that lands in either slot is answered in the same cycle with no flash traffic.

When speculation is turned on, the buffer starts reading the next sequential line as soon as the flash port is free, so straight-line code crosses line boundaries without stalling as long as a flash read is no longer than one line's worth of fetches. When a request lands in neither slot (a branch), any speculative read in flight is dropped, the missing line is read at once, and speculation then resumes from the line after it. A flush input empties both slots.

The flash side is a single-outstanding line-read port: a one-cycle read strobe with a line address, and a completion strobe with the line data. Issuing a new read restarts the flash, so an abandoned read never completes.

Top module: `ifpb_top`

## Requirements
- R1: After reset both slots are empty: with no request pending, `fetch_ready` and `rd_req` are low, and the first request always needs a flash read.
- R2: `fetch_ready` is only high while `fetch_req` is high, and `fetch_data` is then halfword k of the addressed line, k = `fetch_addr[2:1]`, where halfword k occupies line bits [16k+15:16k].
- R3: A request to the line held in the current slot is answered in the cycle it is presented and causes no flash read.
- R4: A request that hits neither slot nor the line being read drives `rd_req` in its first cycle with `rd_line` = `fetch_addr[ADDR_W-1:3]`; with a flash that completes W+1 cycles after issue, `fetch_ready` rises W+1 cycles after the request first appears.
- R5: With `pf_en` low, `rd_req` is only driven for a request that is waiting, and each fetch into a new line waits W+1 cycles.
- R6: With `pf_en` high and W at most 3, a sequential stream of halfword fetches waits only on its first line; every later fetch is answered in its first cycle.
- R7: In the cycle the processor's request first lands in the speculated line (or its arriving read) with the flash port free, the read of the line after it is issued in that same cycle.
- R8: A miss while a speculative read of another line is in flight issues its own read in the same cycle; the dropped line is not installed, so a later fetch into it waits the full W+1 cycles.
- R9: While `flush` is high, `fetch_ready` and `rd_req` stay low; afterwards both slots are empty and a fetch to a previously held line waits W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_en | input | 1 | Enables speculative reads of the next sequential line |
| flush | input | 1 | Empties both line slots and drops any read in flight |
| fetch_req | input | 1 | Instruction fetch request, held until ready |
| fetch_addr | input | ADDR_W-1 | Halfword address (byte address bits ADDR_W-1 down to 1) |
| fetch_ready | output | 1 | Requested halfword is on `fetch_data` this cycle |
| fetch_data | output | 16 | Returned instruction halfword |
| rd_req | output | 1 | One-cycle flash line read strobe |
| rd_line | output | ADDR_W-3 | Line address of the read |
| rd_done | input | 1 | Flash read completes this cycle |
| rd_line_data | input | 64 | Line returned by the flash |

## Verification
The main function is driven with long sequential halfword streams, with isolated branches into fresh lines, with a branch issued while a speculative read is still travelling, and with a seeded random mix of sequential steps and jumps under random wait-state counts. Sequential streams with speculation on separate a design that overlaps the next read with execution from one that only reads on demand, and the stall count of every fetch with speculation off shows whether the current slot is hit-checked correctly. The branch-during-prefetch pattern tells an abandoned read apart from one whose stale line gets installed, and fetches after a flush show whether both slots were really emptied.

// File: rtl/ifpb_pkg.sv
package ifpb_pkg;

    localparam int LINE_W      = 64;
    localparam int HW_W        = 16;
    localparam int HW_PER_LINE = LINE_W / HW_W;
    localparam int IDX_W       = $clog2(HW_PER_LINE);

    typedef enum logic {
        RD_DEMAND   = 1'b0,
        RD_SPECULAT = 1'b1
    } rd_kind_e;

    typedef logic [LINE_W-1:0] line_word_t;
    typedef logic [HW_W-1:0]   half_word_t;

endpackage

// File: rtl/ifpb_line_slot.sv
module ifpb_line_slot
    import ifpb_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [TAG_W-1:0] load_tag,
    input  line_word_t       load_data,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             valid,
    output logic [TAG_W-1:0] tag,
    output line_word_t       data,
    output logic             hit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            tag   <= '0;
            data  <= '0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            tag   <= load_tag;
            data  <= load_data;
        end
    end

    assign hit = valid && (tag == probe_tag);

endmodule

// File: rtl/ifpb_rd_track.sv
module ifpb_rd_track
    import ifpb_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drop,
    input  logic             issue,
    input  logic [TAG_W-1:0] issue_tag,
    input  rd_kind_e         issue_kind,
    input  logic             done,
    output logic             busy,
    output logic [TAG_W-1:0] tag,
    output rd_kind_e         kind,
    output logic             take
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            tag  <= '0;
            kind <= RD_DEMAND;
        end else if (drop) begin
            busy <= 1'b0;
        end else if (issue) begin
            busy <= 1'b1;
            tag  <= issue_tag;
            kind <= issue_kind;
        end else if (done) begin
            busy <= 1'b0;
        end
    end

    assign take = busy && done;

endmodule

// File: rtl/ifpb_hw_sel.sv
module ifpb_hw_sel
    import ifpb_pkg::*;
(
    input  line_word_t       line,
    input  logic [IDX_W-1:0] idx,
    output half_word_t       hw
);

    half_word_t lanes [HW_PER_LINE];

    for (genvar g = 0; g < HW_PER_LINE; g++) begin : g_lane
        assign lanes[g] = line[g*HW_W +: HW_W];
    end

    assign hw = lanes[idx];

endmodule

// File: rtl/ifpb_top.sv
module ifpb_top
    import ifpb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pf_en,
    input  logic                    flush,
    input  logic                    fetch_req,
    input  logic [ADDR_W-1:1]       fetch_addr,
    output logic                    fetch_ready,
    output logic [15:0]             fetch_data,
    output logic                    rd_req,
    output logic [ADDR_W-IDX_W-2:0] rd_line,
    input  logic                    rd_done,
    input  logic [63:0]             rd_line_data
);

    localparam int TAG_W = ADDR_W - 1 - IDX_W;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    assign req_tag = fetch_addr[ADDR_W-1:IDX_W+1];
    assign req_idx = fetch_addr[IDX_W:1];

    // slot and tracker outputs
    logic             cur_v, pf_v, cur_hit, pf_hit;
    logic [TAG_W-1:0] cur_tag, pf_tag;
    line_word_t       cur_data, pf_data;
    logic             tr_busy, tr_take;
    logic [TAG_W-1:0] tr_tag;
    rd_kind_e         tr_kind;

    // slot controls
    logic             cur_ld, pf_ld, pf_clr;
    logic [TAG_W-1:0] cur_ld_tag, pf_ld_tag;
    line_word_t       cur_ld_data, pf_ld_data;

    // request classification
    logic fill_hit, served, served_pf, served_fill;
    assign fill_hit    = tr_take && (tr_tag == req_tag);
    assign served      = fetch_req && !flush && (cur_hit || pf_hit || fill_hit);
    assign served_pf   = served && !cur_hit && pf_hit;
    assign served_fill = served && !cur_hit && !pf_hit && fill_hit;

    // slot update planning
    always_comb begin
        cur_ld      = 1'b0;
        cur_ld_tag  = cur_tag;
        cur_ld_data = cur_data;
        pf_ld       = 1'b0;
        pf_clr      = 1'b0;
        pf_ld_tag   = pf_tag;
        pf_ld_data  = pf_data;
        if (served_pf) begin
            cur_ld      = 1'b1;
            cur_ld_tag  = pf_tag;
            cur_ld_data = pf_data;
            if (tr_take) begin
                pf_ld      = 1'b1;
                pf_ld_tag  = tr_tag;
                pf_ld_data = rd_line_data;
            end else begin
                pf_clr = 1'b1;
            end
        end else if (tr_take && (tr_kind == RD_DEMAND || served_fill)) begin
            cur_ld      = 1'b1;
            cur_ld_tag  = tr_tag;
            cur_ld_data = rd_line_data;
        end else if (tr_take) begin
            pf_ld      = 1'b1;
            pf_ld_tag  = tr_tag;
            pf_ld_data = rd_line_data;
        end
    end

    // slot contents as they will stand after this edge
    logic             cur_n_v, pf_n_v;
    logic [TAG_W-1:0] cur_n_tag, pf_n_tag, next_tag;
    assign cur_n_v   = !flush && (cur_ld || cur_v);
    assign cur_n_tag = cur_ld ? cur_ld_tag : cur_tag;
    assign pf_n_v    = !flush && !pf_clr && (pf_ld || pf_v);
    assign pf_n_tag  = pf_ld ? pf_ld_tag : pf_tag;
    assign next_tag  = cur_n_tag + TAG_W'(1);

    // read issue: a miss wins over speculation
    logic port_free, demand_rd, spec_rd;
    assign port_free = !tr_busy || tr_take;
    assign demand_rd = fetch_req && !flush && !served
                       && !(tr_busy && tr_tag == req_tag);
    assign spec_rd   = !flush && !demand_rd && pf_en && port_free && cur_n_v
                       && !(pf_n_v && pf_n_tag == next_tag);

    assign rd_req  = demand_rd || spec_rd;
    assign rd_line = demand_rd ? req_tag : next_tag;

    ifpb_line_slot #(.TAG_W(TAG_W)) u_cur (
        .clk       (clk),
        .rst       (rst),
        .clr       (flush),
        .load      (cur_ld),
        .load_tag  (cur_ld_tag),
        .load_data (cur_ld_data),
        .probe_tag (req_tag),
        .valid     (cur_v),
        .tag       (cur_tag),
        .data      (cur_data),
        .hit       (cur_hit)
    );

    ifpb_line_slot #(.TAG_W(TAG_W)) u_spec (
        .clk       (clk),
        .rst       (rst),
        .clr       (flush || pf_clr),
        .load      (pf_ld),
        .load_tag  (pf_ld_tag),
        .load_data (pf_ld_data),
        .probe_tag (req_tag),
        .valid     (pf_v),
        .tag       (pf_tag),
        .data      (pf_data),
        .hit       (pf_hit)
    );

    ifpb_rd_track #(.TAG_W(TAG_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .drop       (flush),
        .issue      (rd_req),
        .issue_tag  (rd_line),
        .issue_kind (demand_rd ? RD_DEMAND : RD_SPECULAT),
        .done       (rd_done),
        .busy       (tr_busy),
        .tag        (tr_tag),
        .kind       (tr_kind),
        .take       (tr_take)
    );

    // output halfword
    line_word_t src_line;
    always_comb begin
        if (cur_hit)     src_line = cur_data;
        else if (pf_hit) src_line = pf_data;
        else             src_line = rd_line_data;
    end

    ifpb_hw_sel u_sel (
        .line (src_line),
        .idx  (req_idx),
        .hw   (fetch_data)
    );

    assign fetch_ready = served;

endmodule

// File: rtl/ifpb_chk.sv
module ifpb_chk #(
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              pf_en,
    input logic              flush,
    input logic              fetch_req,
    input logic [ADDR_W-1:1] fetch_addr,
    input logic              fetch_ready,
    input logic              rd_req,
    input logic [TAG_W-1:0]  rd_line,
    input logic              served_pf,
    input logic              tr_busy,
    input logic [TAG_W-1:0]  tr_tag
);

    logic [TAG_W-1:0] a_tag;
    assign a_tag = fetch_addr[ADDR_W-1:3];

    // R2: an answer only goes to a pending request
    p_ready_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        fetch_ready |-> fetch_req);

    // R4: a waiting request that causes a read reads its own line
    p_miss_reads_own_line_r4: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ready && rd_req) |-> (rd_line == a_tag));

    // R5: no speculative traffic while speculation is off
    p_no_spec_when_off_r5: assert property (@(posedge clk) disable iff (rst)
        (!pf_en && rd_req) |-> (fetch_req && !fetch_ready));

    // R7: entering the speculated line with the port idle starts the following read
    p_promote_issues_next_r7: assert property (@(posedge clk) disable iff (rst)
        (served_pf && !tr_busy && pf_en) |-> (rd_req && rd_line == a_tag + TAG_W'(1)));

    // R8: a miss on another line than the one in flight reads at once
    p_branch_abandons_r8: assert property (@(posedge clk) disable iff (rst)
        (tr_busy && fetch_req && !fetch_ready && !flush && tr_tag != a_tag) |-> rd_req);

    // R9: a flush cycle is silent on both ports
    p_flush_silent_r9: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!fetch_ready && !rd_req));

endmodule

bind ifpb_top ifpb_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pf_en       (pf_en),
    .flush       (flush),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .fetch_ready (fetch_ready),
    .rd_req      (rd_req),
    .rd_line     (rd_line),
    .served_pf   (served_pf),
    .tr_busy     (tr_busy),
    .tr_tag      (tr_tag)
);

// File: tb/ifpb_top_tb.sv
module ifpb_top_tb;

    localparam int AW = 16;
    localparam int TW = AW - 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pf_en = 1'b0;
    logic          flush = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:1] fetch_addr = '0;
    logic          fetch_ready;
    logic [15:0]   fetch_data;
    logic          rd_req;
    logic [TW-1:0] rd_line;
    logic          rd_done;
    logic [63:0]   rd_line_data;

    int checks = 0;
    int failures = 0;
    int ws = 0;
    int n_reads = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    ifpb_top #(.ADDR_W(AW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .pf_en        (pf_en),
        .flush        (flush),
        .fetch_req    (fetch_req),
        .fetch_addr   (fetch_addr),
        .fetch_ready  (fetch_ready),
        .fetch_data   (fetch_data),
        .rd_req       (rd_req),
        .rd_line      (rd_line),
        .rd_done      (rd_done),
        .rd_line_data (rd_line_data)
    );

    function automatic logic [15:0] hw_exp(int tag, int k);
        return 16'(tag * 40503 + k * 9973 + 777);
    endfunction

    function automatic logic [63:0] line_exp(int tag);
        logic [63:0] v;
        for (int k = 0; k < 4; k++) v[k*16 +: 16] = hw_exp(tag, k);
        return v;
    endfunction

    // behavioural flash: completes ws+1 cycles after issue, a new read restarts it
    logic          fm_pend = 1'b0;
    int            fm_cnt = 0;
    logic [TW-1:0] fm_tag = '0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_req && !rst) n_reads <= n_reads + 1;
        if (rst) begin
            fm_pend <= 1'b0;
        end else if (rd_req) begin
            fm_pend <= 1'b1;
            fm_cnt  <= ws;
            fm_tag  <= rd_line;
        end else if (fm_pend) begin
            if (fm_cnt == 0) fm_pend <= 1'b0;
            else fm_cnt <= fm_cnt - 1;
        end
    end
    assign rd_done      = fm_pend && (fm_cnt == 0);
    assign rd_line_data = line_exp(int'(fm_tag));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 190000) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            finish_run();
        end
    end

    // results of the last fetch
    int            stall;
    logic          first_rd;
    logic [TW-1:0] first_line;
    logic          ready_rd;
    logic [TW-1:0] ready_line;

    task automatic fetch(input int a, input string req);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a[AW-1:1];
        stall = 0;
        #1;
        first_rd   = rd_req;
        first_line = rd_line;
        while (!fetch_ready && stall < 64) begin
            @(negedge clk);
            #1;
            stall++;
        end
        ready_rd   = rd_req;
        ready_line = rd_line;
        check(fetch_ready == 1'b1, req, "ready", fetch_ready, 1);
        check(fetch_data == hw_exp(a >> 3, (a >> 1) & 3), "R2", "data",
              fetch_data, hw_exp(a >> 3, (a >> 1) & 3));
        @(posedge clk);
        #1;
        fetch_req = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        fetch_req = 1'b0;
        flush = 1'b1;
        #1;
        check(!fetch_ready && !rd_req, "R9", "flush silent", {fetch_ready, rd_req}, 0);
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        int a;
        int r0;
        int last_line;
        int seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!fetch_ready && !rd_req, "R1", "idle after reset", {fetch_ready, rd_req}, 0);

        // demand reads, speculation off
        ws = 5;
        pf_en = 1'b0;
        fetch('h100, "R4");
        check(stall == ws + 1, "R1", "first fetch stall", stall, ws + 1);
        check(first_rd && first_line == TW'('h100 >> 3), "R4", "read in request cycle",
              {first_rd, first_line}, {1'b1, TW'('h20)});
        r0 = n_reads;
        fetch('h106, "R3");
        check(stall == 0, "R3", "same line hit", stall, 0);
        fetch('h102, "R3");
        check(stall == 0, "R3", "same line hit", stall, 0);
        check(n_reads == r0, "R3", "no read on hit", n_reads, r0);
        fetch('h108, "R5");
        check(stall == ws + 1, "R5", "new line stall", stall, ws + 1);
        repeat (10) @(posedge clk);
        check(n_reads == r0 + 1, "R5", "no speculative reads", n_reads, r0 + 1);

        // sequential streams, speculation on
        for (int w = 0; w <= 3; w++) begin
            ws = w;
            pf_en = 1'b1;
            do_flush();
            for (int i = 0; i < 24; i++) begin
                a = 'h200 + w * 'h80 + 2 * i;
                fetch(a, "R6");
                if (i == 0) check(stall == ws + 1, "R6", "first line stall", stall, ws + 1);
                else check(stall == 0, "R6", "sequential no stall", stall, 0);
                if (i % 4 == 0 && i != 0)
                    check(ready_rd && ready_line == TW'((a >> 3) + 1), "R7",
                          "next read on line entry", {ready_rd, ready_line},
                          {1'b1, TW'((a >> 3) + 1)});
            end
        end

        // branch during speculation
        ws = 10;
        do_flush();
        fetch('h300, "R4");
        check(stall == ws + 1, "R4", "miss stall", stall, ws + 1);
        fetch('h500, "R8");
        check(first_rd && first_line == TW'('h500 >> 3), "R8", "branch reads at once",
              {first_rd, first_line}, {1'b1, TW'('hA0)});
        check(stall == ws + 1, "R8", "branch stall", stall, ws + 1);
        fetch('h308, "R8");
        check(stall == ws + 1, "R8", "dropped line not installed", stall, ws + 1);
        fetch('h30A, "R3");
        check(stall == 0, "R3", "hit after fill", stall, 0);
        do_flush();
        fetch('h30A, "R9");
        check(stall == ws + 1, "R9", "miss after flush", stall, ws + 1);

        // seeded random mix
        seed = $urandom(1234);
        a = 'h40;
        for (int s = 0; s < 12; s++) begin
            pf_en = 1'($urandom_range(0, 1));
            ws = $urandom_range(0, 15);
            do_flush();
            last_line = -1;
            for (int i = 0; i < 40; i++) begin
                if ($urandom_range(0, 9) < 8) a = (a + 2) & 'hFFFE;
                else a = 2 * $urandom_range(0, 'h3FF);
                fetch(a, pf_en ? "R6" : "R5");
                if (!pf_en) begin
                    check(stall == (((a >> 3) == last_line) ? 0 : ws + 1), "R5",
                          "random stall", stall,
                          ((a >> 3) == last_line) ? 0 : ws + 1);
                end else begin
                    check(stall <= ws + 1, "R4", "random stall bound", stall, ws + 1);
                end
                last_line = a >> 3;
            end
        end
        finish_run();
    end

endmodule